// File: doc/BRIEF.md
# Alarm-Armed Periodic Pulse Generator

This block watches a free-running 64-bit nanosecond time value and produces periodic output pulses whose phase is tied to an absolute time chosen by software. It has two 64-bit alarm comparators and three interval channels. Software loads a 32-bit interval into a channel and picks which alarm starts it. When the time value reaches the armed alarm, that alarm fires once. Every enabled channel that listens to it loads its interval and then counts down by a fixed step of nanoseconds on each time update. Each time the interval runs out, the channel records an event and can drive a pulse of programmable width on its output pin.

Event status bits are sticky and are cleared by writing one. A mask register selects which status bits drive the single interrupt line. A typical use is a pulse-per-second source. Software arms an alarm at the next whole second, sets the interval to one second, and re-arms the alarm after any step or rate change of the time base so that the pulses realign.

Top module: `pulse_alarm_timer`

## Requirements
- R1: After reset, both alarms and all three intervals read all ones. The control word reads 0x00808080, so every channel starts disabled. The status and mask registers read zero, and `pulse_out` and `irq` are low.
- R2: The register word addresses are as follows. Status is at 0, mask at 1 and control at 2. Alarm 0 low and high are at 3 and 4, and alarm 1 low and high are at 5 and 6. Intervals 0 to 2 are at 7 to 9. Reads return the addressed register in the same cycle.
- R3: A write to an alarm's high word arms it, unless the complete 64-bit value is then all ones. A write to its low word disarms it. An armed alarm fires on a time update at which the time value is greater than or equal to the alarm. Its status bit 16+a is set on the following clock.
- R4: An alarm fires once per arming. It takes no further action until its high word is written again.
- R5: Channel i has a control byte at bits 8i+7 to 8i. Bit 7 disables the channel and bit 6 enables the pulse output. Bit 5 selects the starting alarm, with 0 for alarm 0 and 1 for alarm 1. Bits 4:0 give the pulse width in clock cycles.
- R6: Assume one time update per clock and an interval that is a multiple of the step STEP_NS, where N = interval/STEP_NS. The first pulse of an enabled channel begins N cycles after its alarm's status bit becomes visible, and later pulses begin every N cycles.
- R7: Each pulse stays high for exactly the programmed width in cycles. If the pulse enable bit is clear, the pin stays low, but the event is still recorded.
- R8: Each expiry of channel i sets status bit 7-i.
- R9: While the disable bit is set, the channel's pin is low and it records no events. After the bit is cleared, pulsing resumes only when the selected alarm fires again.
- R10: Writing a status word clears the bits written as one and leaves the bits written as zero unchanged. An event arriving in the same cycle as its clear wins.
- R11: `irq` is high exactly when some status bit is set whose mask bit is also set.
- R12: A channel whose interval is all ones does not start when its alarm fires. If it was already running, it stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_ns | input | 64 | Current time in nanoseconds |
| time_tick | input | 1 | Time update strobe; counters step and alarms compare only on it |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pulse_out | output | 3 | Pulse output per channel |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The hardest case to reach is a re-enabled channel that must stay silent until it is re-armed. This needs an alarm that has already been spent, followed by a disable of a running channel and then a fresh enable. The stimulus sets this up directly. It runs a pulse train from one alarm and sets the disable bit in the middle of the train. It then clears the bit and watches the pin and status for a full window, and only then re-arms the alarm to confirm that the pulses return. The selection between alarms is checked by firing the wrong alarm first and confirming that the channel stays quiet.

// File: rtl/ppg_pkg.sv
// Shared constants for the alarm-armed pulse generator: register word
// addresses, control-byte field positions and event bit positions.
// Assumes one control byte per channel and a 32-bit register word.
package ppg_pkg;
    localparam int CTRL_BYTE  = 8;   // control bits per channel
    localparam int CB_DIS     = 7;   // channel disable
    localparam int CB_PG      = 6;   // pulse output enable
    localparam int CB_SRC     = 5;   // alarm select
    localparam int PW_W       = 5;   // pulse width field width
    localparam int EV_PULSE_TOP = 7; // channel i event at bit 7-i
    localparam int EV_ALM_BASE  = 16;// alarm a event at bit 16+a
    localparam int A_STAT     = 0;
    localparam int A_MASK     = 1;
    localparam int A_CTRL     = 2;
    localparam int A_ALM_BASE = 3;   // alarm a low at 3+2a, high at 4+2a
endpackage

// File: rtl/ppg_alarm.sv
// One 64-bit alarm comparator. Writing the high word arms it (unless the
// whole value is all ones), writing the low word disarms it. When armed it
// compares against the time value on each update and fires once.
// Assumes the time value only moves forward between arming and firing.
module ppg_alarm #(
    parameter int TW = 64,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_ns,
    input  logic          time_tick,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [RW-1:0] wdata,
    output logic [TW-1:0] alarm_val,
    output logic          fire
);
    logic          armed;
    logic [TW-1:0] nxt_val;

    // Merge a word write into the current alarm value.
    always_comb begin
        nxt_val = alarm_val;
        if (wr_lo) nxt_val[RW-1:0]  = wdata;
        if (wr_hi) nxt_val[TW-1:RW] = wdata[TW-RW-1:0];
    end

    // Hold the alarm value, arming state and the one-shot fire strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_val <= '1;
            armed     <= 1'b0;
            fire      <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (wr_lo || wr_hi) begin
                alarm_val <= nxt_val;
                armed     <= wr_hi && !wr_lo && (nxt_val != '1);
            end else if (armed && time_tick && (time_ns >= alarm_val)) begin
                fire  <= 1'b1;
                armed <= 1'b0;
            end
        end
    end

    assert_fire_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire) |-> $past(armed));
    assert_single_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/ppg_chan.sv
// One interval channel. A start strobe loads the interval and begins the
// countdown; each time update subtracts STEP nanoseconds. On expiry the
// remainder carries into the next interval, an event strobe is raised and,
// if enabled, a pulse of the given width in clock cycles is driven.
// Assumes interval >= STEP when the channel runs.
module ppg_chan #(
    parameter int RW   = 32,
    parameter int PW   = 5,
    parameter int STEP = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          time_tick,
    input  logic          start,
    input  logic          dis,
    input  logic          pg_en,
    input  logic [PW-1:0] pw_set,
    input  logic [RW-1:0] interval,
    output logic          expire,
    output logic          pulse
);
    localparam logic [RW-1:0] STEP_V = RW'(STEP);

    logic          running;
    logic [RW-1:0] cnt;
    logic [PW-1:0] pw_cnt;
    logic          hit;

    // Expiry condition on this update.
    assign hit = running && !dis && !start && time_tick && (cnt <= STEP_V);

    // Countdown, run state and event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '1;
            expire  <= 1'b0;
        end else begin
            expire <= hit;
            if (dis) begin
                running <= 1'b0;
                cnt     <= interval;
            end else if (start) begin
                running <= (interval != '1);
                cnt     <= interval;
            end else if (hit) begin
                cnt <= cnt + (interval - STEP_V);
            end else if (running && time_tick) begin
                cnt <= cnt - STEP_V;
            end
        end
    end

    // Pulse width counter, reloaded on each enabled expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)              pw_cnt <= '0;
        else if (dis)            pw_cnt <= '0;
        else if (hit && pg_en)   pw_cnt <= pw_set;
        else if (pw_cnt != '0)   pw_cnt <= pw_cnt - 1'b1;
    end

    assign pulse = (pw_cnt != '0) && !dis;

    assert_dis_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (cnt == $past(interval)) && !expire);
    assert_width_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(expire) == 1'b0 && $past(running));
endmodule

// File: rtl/ppg_events.sv
// Sticky event status with write-one-to-clear, a mask register and the
// interrupt. A set arriving in the same cycle as its clear takes priority.
// Assumes VALID marks the implemented event bits.
module ppg_events #(
    parameter int          RW    = 32,
    parameter logic [31:0] VALID = 32'h0003_00E0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] set_vec,
    input  logic          wr_stat,
    input  logic          wr_mask,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] status,
    output logic [RW-1:0] mask,
    output logic          irq
);
    logic [RW-1:0] clr;

    assign clr = wr_stat ? wdata : '0;

    // Latch events and apply write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= ((status & ~clr) | set_vec) & VALID[RW-1:0];
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (wr_mask) mask <= wdata & VALID[RW-1:0];
    end

    assign irq = |(status & mask);

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((status & $past(wdata & ~set_vec)) == '0));
endmodule

// File: rtl/pulse_alarm_timer.sv
// Top of the alarm-armed pulse generator: register file, two alarm
// comparators, three interval channels and the event/interrupt logic.
// Assumes time_ns advances by STEP_NS on every time_tick.
module pulse_alarm_timer
    import ppg_pkg::*;
#(
    parameter int TIME_W  = 64,
    parameter int REG_W   = 32,
    parameter int ADDR_W  = 4,
    parameter int N_ALM   = 2,
    parameter int N_CH    = 3,
    parameter int STEP_NS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_ns,
    input  logic              time_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [N_CH-1:0]   pulse_out,
    output logic              irq
);
    localparam int CTRL_W     = N_CH * CTRL_BYTE;
    localparam int A_IVL_BASE = A_ALM_BASE + 2 * N_ALM;

    logic [CTRL_W-1:0] ctrl_q;
    logic [REG_W-1:0]  ivl_q   [N_CH];
    logic [TIME_W-1:0] alm_val [N_ALM];
    logic [N_ALM-1:0]  fire;
    logic [N_CH-1:0]   expire;
    logic [REG_W-1:0]  set_vec, status, mask;
    logic              wr_stat, wr_mask, wr_ctrl;

    assign wr_stat = reg_we && (reg_addr == ADDR_W'(A_STAT));
    assign wr_mask = reg_we && (reg_addr == ADDR_W'(A_MASK));
    assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(A_CTRL));

    // Channel control bytes; every channel disabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= {N_CH{8'h80}};
        else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    genvar g;
    generate
        for (g = 0; g < N_ALM; g++) begin : g_alm
            ppg_alarm #(.TW(TIME_W), .RW(REG_W)) u_alarm (
                .clk      (clk),
                .rst_n    (rst_n),
                .time_ns  (time_ns),
                .time_tick(time_tick),
                .wr_lo    (reg_we && (reg_addr == ADDR_W'(A_ALM_BASE + 2*g))),
                .wr_hi    (reg_we && (reg_addr == ADDR_W'(A_ALM_BASE + 2*g + 1))),
                .wdata    (reg_wdata),
                .alarm_val(alm_val[g]),
                .fire     (fire[g])
            );
        end

        for (g = 0; g < N_CH; g++) begin : g_ch
            // Interval register for this channel.
            always_ff @(posedge clk) begin
                if (!rst_n) ivl_q[g] <= '1;
                else if (reg_we && (reg_addr == ADDR_W'(A_IVL_BASE + g)))
                    ivl_q[g] <= reg_wdata;
            end

            ppg_chan #(.RW(REG_W), .PW(PW_W), .STEP(STEP_NS)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .time_tick(time_tick),
                .start    (fire[ctrl_q[g*CTRL_BYTE + CB_SRC]]),
                .dis      (ctrl_q[g*CTRL_BYTE + CB_DIS]),
                .pg_en    (ctrl_q[g*CTRL_BYTE + CB_PG]),
                .pw_set   (ctrl_q[g*CTRL_BYTE +: PW_W]),
                .interval (ivl_q[g]),
                .expire   (expire[g]),
                .pulse    (pulse_out[g])
            );
        end
    endgenerate

    // Place channel and alarm strobes at their status bit positions.
    always_comb begin
        set_vec = '0;
        for (int c = 0; c < N_CH; c++) set_vec[EV_PULSE_TOP - c] = expire[c];
        for (int a = 0; a < N_ALM; a++) set_vec[EV_ALM_BASE + a] = fire[a];
    end

    ppg_events #(.RW(REG_W)) u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .wr_stat(wr_stat),
        .wr_mask(wr_mask),
        .wdata  (reg_wdata),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_STAT)) reg_rdata = status;
        if (reg_addr == ADDR_W'(A_MASK)) reg_rdata = mask;
        if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata[CTRL_W-1:0] = ctrl_q;
        for (int a = 0; a < N_ALM; a++) begin
            if (reg_addr == ADDR_W'(A_ALM_BASE + 2*a))
                reg_rdata = alm_val[a][REG_W-1:0];
            if (reg_addr == ADDR_W'(A_ALM_BASE + 2*a + 1))
                reg_rdata = alm_val[a][TIME_W-1:REG_W];
        end
        for (int c = 0; c < N_CH; c++)
            if (reg_addr == ADDR_W'(A_IVL_BASE + c)) reg_rdata = ivl_q[c];
    end

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_mask) || ($past(set_vec) != '0));
endmodule

// File: tb/test_pulse_alarm_timer.sv
module test_pulse_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] now;
    logic        tick = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  pulse_out;
    logic        irq;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) now <= 64'd0;
        else        now <= now + 64'd10;
    end

    pulse_alarm_timer i_pulse_alarm_timer (
        .clk(clk), .rst_n(rst_n), .time_ns(now), .time_tick(tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pulse_out(pulse_out), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(addr); reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        reg_addr = 4'(addr);
        #1 data = reg_rdata;
    endtask

    task automatic arm(input int a, input logic [63:0] val);
        wr(3 + 2*a, val[31:0]);
        wr(4 + 2*a, val[63:32]);
    endtask

    task automatic wait_bit(input int b, input int limit, output int at);
        at = -1;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk); reg_addr = 4'd0; #1;
            if (reg_rdata[b]) begin at = cyc; break; end
        end
    endtask

    task automatic wait_rise(input int ch, input int limit, output int at);
        at = -1;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (pulse_out[ch]) begin at = cyc; break; end
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(0, d); check("R1 status", d, 0);
        rd(1, d); check("R1 mask", d, 0);
        rd(2, d); check("R1 ctrl", d, 32'h0080_8080);
        rd(4, d); check("R1 alarm0 hi", d, 32'hFFFF_FFFF);
        rd(5, d); check("R1 alarm1 lo", d, 32'hFFFF_FFFF);
        rd(9, d); check("R1 interval2", d, 32'hFFFF_FFFF);
        check("R1 outputs", {pulse_out, irq}, 0);
        wr(8, 32'h1234_5678); rd(8, d); check("R2 interval1 readback", d, 32'h1234_5678);
    endtask

    task automatic t_alarm_once;
        logic [31:0] d;
        wr(1, 32'h0001_0000);
        arm(0, now + 64'd100);
        repeat (20) @(negedge clk);
        rd(0, d); check("R3 alarm0 status", d[16], 1);
        check("R11 irq on masked alarm", irq, 1);
        wr(0, 32'h0001_0000);
        rd(0, d); check("R10 clear alarm bit", d[16], 0);
        check("R11 irq low after clear", irq, 0);
        repeat (20) @(negedge clk);
        rd(0, d); check("R4 no second fire", d[16], 0);
        arm(0, 64'hFFFF_FFFF_FFFF_FFFF);
        repeat (10) @(negedge clk);
        rd(0, d); check("R3 all ones never fires", d[16], 0);
        wr(3, now[31:0] + 32'd50);
        repeat (20) @(negedge clk);
        rd(0, d); check("R3 low write alone does not arm", d[16], 0);
        wr(1, 32'h0);
    endtask

    task automatic t_train;
        int ca, p1, p2, len;
        logic [31:0] d;
        wr(7, 32'd50);
        wr(2, 32'h0080_8043);
        wr(0, 32'h0003_00E0);
        arm(0, now + 64'd150);
        wait_bit(16, 40, ca);
        wait_rise(0, 20, p1);
        check("R6 first pulse delay", p1 - ca, 5);
        len = 1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!pulse_out[0]) break;
            len++;
        end
        check("R7 pulse width", len, 3);
        wait_rise(0, 20, p2);
        check("R6 pulse spacing", p2 - p1, 5);
        rd(0, d); check("R8 channel0 event bit7", d[7], 1);
        wr(1, 32'h0000_0080);
        check("R11 irq from channel event", irq, 1);
        wr(1, 32'h0);
        check("R11 irq masked off", irq, 0);
    endtask

    task automatic t_disable;
        int seen, at;
        logic [31:0] d;
        wr(2, 32'h0080_80C3);
        @(negedge clk);
        wr(0, 32'h0003_00E0);
        seen = 0;
        for (int k = 0; k < 30; k++) begin @(negedge clk); if (pulse_out[0]) seen = 1; end
        check("R9 disabled pin low", seen, 0);
        rd(0, d); check("R9 disabled no event", d[7], 0);
        wr(2, 32'h0080_8043);
        wr(0, 32'h0003_00E0);
        seen = 0;
        for (int k = 0; k < 30; k++) begin @(negedge clk); if (pulse_out[0]) seen = 1; end
        check("R9 re-enable waits for alarm", seen, 0);
        rd(0, d); check("R9 re-enable no event", d[7], 0);
        arm(0, now + 64'd100);
        wait_rise(0, 40, at);
        check("R9 resumes after re-arm", at >= 0, 1);
    endtask

    task automatic t_alarm_select;
        int seen, at;
        logic [31:0] d;
        wr(9, 32'd30);
        wr(2, 32'h0062_80C3);
        wr(0, 32'h0003_00E0);
        arm(0, now + 64'd100);
        seen = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (pulse_out[2]) seen = 1; end
        check("R5 alarm0 does not start ch2", seen, 0);
        rd(0, d); check("R5 ch2 no event on alarm0", d[5], 0);
        arm(1, now + 64'd100);
        wait_rise(2, 40, at);
        check("R5 alarm1 starts ch2", at >= 0, 1);
        rd(0, d); check("R8 ch2 event bit5 and alarm1 bit17", {d[17], d[5]}, 2'b11);
    endtask

    task automatic t_no_pg;
        int seen, at;
        logic [31:0] d;
        wr(8, 32'd40);
        wr(2, 32'h0062_05C3);
        wr(0, 32'h0003_00E0);
        arm(0, now + 64'd100);
        seen = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (pulse_out[1]) seen = 1; end
        check("R7 pulse enable clear keeps pin low", seen, 0);
        rd(0, d); check("R7 event still recorded bit6", d[6], 1);
        wr(8, 32'hFFFF_FFFF);
        wr(2, 32'h0062_45C3);
        arm(0, now + 64'd60);
        wait_bit(16, 30, at);
        @(negedge clk);
        wr(0, 32'h0003_00E0);
        seen = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (pulse_out[1]) seen = 1; end
        check("R12 all-ones interval no pulse", seen, 0);
        rd(0, d); check("R12 all-ones interval no event", d[6], 0);
    endtask

    task automatic t_w1c_partial;
        int at;
        logic [31:0] d;
        arm(0, now + 64'd60);
        wait_bit(16, 30, at);
        wr(0, 32'h0);
        rd(0, d); check("R10 writing zero keeps bit16", d[16], 1);
        wr(0, 32'h0002_0000);
        rd(0, d); check("R10 clearing bit17 keeps bit16", d[16], 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alarm_once();
        t_train();
        t_disable();
        t_alarm_select();
        t_no_pg();
        t_w1c_partial();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule